// File: doc/BRIEF.md
# Sequential Mask/Value Trigger

This block watches a stream of wide samples and decides when an acquisition has met its trigger condition. The stream is qualified by a sample-enable input. A small set of ordered stages is evaluated one after another. Each stage has its own mask and compare value, and a matching sample moves the hunt on to the next stage.

One stage is tagged as the final stage through a per-stage flag. When a sample matches that stage, the block emits a one-cycle trigger pulse and starts a post-trigger count. The count is loaded from a programmable length. When the count runs out, the capture is finished and the done flag rises. Where the trigger lands within the capture therefore depends on the length value.

Software arms the block with a single strobe. The stage index is visible at the ports, so it can be watched while the block is hunting.

Top module: `seq_trigger`

## Requirements
- R1: After reset, the stage index is 0, and trig, active and done are all low.
- R2: An arm strobe sets the stage index to 0, raises active and clears done on the next cycle, in any state. The sample presented in the arm cycle is not evaluated.
- R3: Stage k matches a sample when the sample and the compare value of stage k are equal in every bit where the mask of stage k is 1. Stage k uses bits [32k+31:32k] of the mask and value buses. A mismatch leaves the stage index unchanged.
- R4: A sample is evaluated only in a cycle where smp_en is high. Cycles with smp_en low change neither the stage index nor the post-trigger count.
- R5: While hunting, a match on a stage whose final flag is clear raises the stage index by one. At the last stage the index holds.
- R6: A match on the current stage when its bit in stg_final is 1 drives trig high for exactly one cycle, in the cycle after that sample. The stage index then holds until the next arm.
- R7: When stage 0 has an all-zero mask and its final flag set, the first enabled sample after arming produces the trigger.
- R8: After the trigger, exactly post_len+1 further enabled samples are taken. Active falls and done rises in the cycle after the last of them.
- R9: Done stays high until the next arm strobe. Samples that arrive while the block is idle or done cause no trigger and no stage change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle strobe that restarts the hunt at stage 0 |
| smp_en | input | 1 | Qualifies smp for the current cycle |
| smp | input | W | Sample word |
| stg_mask | input | NSTG*W | Per-stage masks; stage k at bits [W*k+W-1:W*k] |
| stg_value | input | NSTG*W | Per-stage compare values, laid out like stg_mask |
| stg_final | input | NSTG | Bit k set marks stage k as the final stage |
| post_len | input | CW | Post-trigger samples minus one |
| trig | output | 1 | One-cycle trigger pulse |
| active | output | 1 | High from arm until the capture ends |
| done | output | 1 | High once the post-trigger count has run out |
| stage | output | SW | Current stage index |

## Verification
A wrong stage register is seen at the stage port in the cycle after the sample that caused it. It also shifts the trigger pulse by at least one enabled sample. A post-trigger count that is off by one makes done rise one enabled sample early or late, and the checks look for the exact cycle. A state machine stuck after done, or one that does not restart on arm, fails at the active and done flags one cycle after the strobe.

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int W    = 32,
  parameter int NSTG = 4,
  parameter int CW   = 16,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              smp_en,
  input  logic [W-1:0]      smp,
  input  logic [NSTG*W-1:0] stg_mask,
  input  logic [NSTG*W-1:0] stg_value,
  input  logic [NSTG-1:0]   stg_final,
  input  logic [CW-1:0]     post_len,
  output logic              trig,
  output logic              active,
  output logic              done,
  output logic [SW-1:0]     stage
);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_POST, S_DONE} st_t;
  localparam logic [SW-1:0] LAST = SW'(NSTG - 1);

  st_t st;
  logic [CW-1:0] cnt;
  logic [NSTG-1:0] hit;

  for (genvar g = 0; g < NSTG; g++) begin : g_cmp
    assign hit[g] = ((smp ^ stg_value[g*W +: W]) & stg_mask[g*W +: W]) == '0;
  end

  wire cur_hit = hit[stage];
  wire cur_fin = stg_final[stage];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      stage <= '0;
      cnt   <= '0;
      trig  <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (arm) begin
        st    <= S_HUNT;
        stage <= '0;
        cnt   <= '0;
      end else begin
        case (st)
          S_HUNT:
            if (smp_en && cur_hit) begin
              if (cur_fin) begin
                st   <= S_POST;
                trig <= 1'b1;
                cnt  <= post_len;
              end else if (stage != LAST) begin
                stage <= stage + 1'b1;
              end
            end
          S_POST:
            if (smp_en) begin
              if (cnt == '0) st <= S_DONE;
              else           cnt <= cnt - 1'b1;
            end
          default: ;
        endcase
      end
    end
  end

  assign active = (st == S_HUNT) || (st == S_POST);
  assign done   = (st == S_DONE);

endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk #(
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          smp_en,
  input logic          trig,
  input logic          active,
  input logic          done,
  input logic [SW-1:0] stage
);

  p_arm_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (stage == '0 && active && !done));

  p_idle_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !smp_en) |=> ($stable(stage) && !trig));

  p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (stage == $past(stage)) || (stage == SW'($past(stage) + 1'b1)));

  p_trig_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  p_trig_in_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> active);

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && active));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

endmodule

bind seq_trigger seq_trigger_chk #(.SW(SW)) i_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en),
  .trig(trig), .active(active), .done(done), .stage(stage)
);

// File: tb/test_seq_trigger.sv
module test_seq_trigger;
  localparam int W = 32, NSTG = 4, CW = 16, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, smp_en = 1'b0;
  logic [W-1:0] smp = '0;
  logic [NSTG*W-1:0] stg_mask = '0, stg_value = '0;
  logic [NSTG-1:0] stg_final = '0;
  logic [CW-1:0] post_len = '0;
  logic trig, active, done;
  logic [SW-1:0] stage;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  seq_trigger #(.W(W), .NSTG(NSTG), .CW(CW)) i_seq_trigger (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_en(smp_en), .smp(smp),
    .stg_mask(stg_mask), .stg_value(stg_value), .stg_final(stg_final),
    .post_len(post_len), .trig(trig), .active(active), .done(done), .stage(stage)
  );

  // arm, en, smp[31:0], stage[1:0], trig, active, done
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h00000000, 2'd0, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h00000011, 2'd1, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h00000000, 2'd1, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b0, 32'h00002200, 2'd1, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h00002200, 2'd2, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h50000000, 2'd2, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'hA1234567, 2'd2, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h00000000, 2'd2, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b0, 32'h00000000, 2'd2, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h00000000, 2'd2, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'h00000000, 2'd2, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 32'h00000011, 2'd2, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'h00000011, 2'd0, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 32'hFFFFFF11, 2'd1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic e, input logic [W-1:0] s);
    arm = a; smp_en = e; smp = s;
    @(posedge clk); #1;
    arm = 1'b0; smp_en = 1'b0;
  endtask

  task automatic flags(input string req, input logic [SW-1:0] st, input logic t, input logic ac, input logic dn);
    chk(req, "stage", 32'(stage), 32'(st));
    chk(req, "trig", 32'(trig), 32'(t));
    chk(req, "active", 32'(active), 32'(ac));
    chk(req, "done", 32'(done), 32'(dn));
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    flags("R1", 2'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9: not armed, matching samples ignored
    stg_mask = '0; stg_final = 4'b0001;
    cyc(1'b0, 1'b1, 32'h12345678);
    flags("R9", 2'd0, 1'b0, 1'b0, 1'b0);

    // table: R3 R4 R5 R6 R8 R9 R2
    stg_mask  = {32'h00000000, 32'hF0000000, 32'h0000FF00, 32'h000000FF};
    stg_value = {32'h00000000, 32'hA0000000, 32'h00002200, 32'h00000011};
    stg_final = 4'b0100;
    post_len  = 16'd2;
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][38], VEC[i][37], VEC[i][36:5]);
      chk("R3_R5", $sformatf("vec%0d stage", i), 32'(stage), 32'(VEC[i][4:3]));
      chk("R6", $sformatf("vec%0d trig", i), 32'(trig), 32'(VEC[i][2]));
      chk("R8", $sformatf("vec%0d active", i), 32'(active), 32'(VEC[i][1]));
      chk("R9", $sformatf("vec%0d done", i), 32'(done), 32'(VEC[i][0]));
    end

    // R7: empty mask on final stage 0, R8 with post_len 0
    stg_mask = '0; stg_final = 4'b0001; post_len = 16'd0;
    cyc(1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, 32'hDEADBEEF);
    flags("R7", 2'd0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 32'h0);
    flags("R8", 2'd0, 1'b0, 1'b0, 1'b1);

    // R5: no final flag, index saturates at last stage
    stg_final = 4'b0000;
    cyc(1'b1, 1'b0, '0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 32'(i));
    flags("R5", 2'd3, 1'b0, 1'b1, 1'b0);

    // R2: arm during post-trigger window restarts the hunt
    stg_final = 4'b0001; post_len = 16'd5;
    cyc(1'b1, 1'b0, '0);
    cyc(1'b0, 1'b1, '0);
    chk("R6", "trig", 32'(trig), 32'd1);
    cyc(1'b0, 1'b1, '0);
    cyc(1'b1, 1'b1, '0);
    flags("R2", 2'd0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0);
    chk("R2", "retrigger", 32'(trig), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule